// File: doc/BRIEF.md
# Transmit Descriptor Status Engine

This block walks a ring of transmit descriptors for a descriptor-driven Ethernet MAC. Software hands over work by moving a produce index ahead of the consume index that the block owns. Each slot between the two indices is one fragment. The block takes the fragment at the consume index, latches that slot's "last fragment" and "interrupt request" flags, and presents the fragment to the MAC through a simple hold-until-done interface.

When the MAC reports completion together with its collision, deferral, abort and underrun results, the block builds one 32-bit status word for that fragment. It issues a single status write strobe carrying the slot number and advances the consume index in the same cycle. It can also latch an interrupt. Collision and deferral results appear only in the status of a frame's last fragment. Underrun, missing-descriptor and the summary error bit are valid on every fragment.

If a fragment that leaves its frame open completes while the ring holds no further descriptor, the block reports the missing descriptor in that fragment's status and treats the frame as aborted.

Top module: `tx_status_engine`

## Requirements
- R1: After reset, `cons_idx` is 0, and `frag_valid`, `stat_we` and `irq` are low.
- R2: While idle with `cons_idx` different from `prod_idx`, the block raises `frag_valid` on the next cycle. It then presents `frag_slot` equal to `cons_idx` and `frag_last` equal to the `desc_last` value it latched. While the indices are equal, no fragment is presented.
- R3: A `mac_done` pulse during a presented fragment produces exactly one `stat_we` pulse on the following cycle. In that same cycle `stat_slot` holds the finished slot and `cons_idx` has advanced by one, wrapping from RING-1 to 0.
- R4: Bits 20:0 of `stat_word` are always zero.
- R5: For a last fragment, the status fields are copied from the MAC: bits 24:21 hold the collision count clamped to MAX_RETX, bit 25 is deferral, bit 26 is excessive deferral, bit 27 is excessive collisions and bit 28 is late collision.
- R6: For a fragment whose latched last flag is clear, bits 28:21 are zero regardless of the MAC inputs.
- R7: Bit 29 reports the MAC underrun on every fragment. Bit 31 equals the OR of bits 26, 27, 28, 29 and 30.
- R8: Bit 30 (missing descriptor) is set exactly when a non-last fragment completes and the slot after it equals `prod_idx`.
- R9: `irq` is set by a status write whose descriptor had `desc_irq` set, and stays high until an `irq_clr` pulse. A set and a clear in the same cycle leave `irq` high.
- R10: A `mac_done` pulse while no fragment is presented produces no status write and leaves `cons_idx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_idx | input | IW | Software produce index |
| desc_last | input | 1 | Last-fragment flag of the descriptor at `cons_idx` |
| desc_irq | input | 1 | Interrupt-request flag of the descriptor at `cons_idx` |
| frag_valid | output | 1 | Fragment presented to the MAC |
| frag_slot | output | IW | Ring slot of the presented fragment |
| frag_last | output | 1 | Latched last flag of the presented fragment |
| mac_done | input | 1 | MAC finished the presented fragment |
| mac_coll_cnt | input | 4 | Collisions seen by the MAC |
| mac_defer | input | 1 | Medium was busy before sending |
| mac_exc_defer | input | 1 | Deferral limit exceeded, aborted |
| mac_exc_coll | input | 1 | Collision limit exceeded, aborted |
| mac_late_coll | input | 1 | Out-of-window collision, aborted |
| mac_underrun | input | 1 | Transmit data not supplied in time |
| stat_we | output | 1 | Status write strobe |
| stat_slot | output | IW | Slot the status word belongs to |
| stat_word | output | 32 | Status word |
| cons_idx | output | IW | Consume index |
| irq | output | 1 | Latched interrupt |
| irq_clr | input | 1 | Interrupt clear pulse |

## Verification
A wrong consume index shows up as the wrong `frag_slot` when the next fragment is presented. It also shows as a `stat_slot` and `cons_idx` pair that disagrees on the strobe cycle, one cycle after `mac_done`. A wrongly latched last flag shows on the next status word, either as leaked collision fields on an open fragment or as a missing or spurious missing-descriptor bit. A stuck busy state shows within a few cycles as `frag_valid` either never rising or never falling.

// File: rtl/tx_status_engine.sv
module tx_status_engine #(
  parameter int RING = 6,
  parameter int MAX_RETX = 10,
  localparam int IW = (RING > 1) ? $clog2(RING) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] prod_idx,
  input  logic          desc_last,
  input  logic          desc_irq,
  output logic          frag_valid,
  output logic [IW-1:0] frag_slot,
  output logic          frag_last,
  input  logic          mac_done,
  input  logic [3:0]    mac_coll_cnt,
  input  logic          mac_defer,
  input  logic          mac_exc_defer,
  input  logic          mac_exc_coll,
  input  logic          mac_late_coll,
  input  logic          mac_underrun,
  output logic          stat_we,
  output logic [IW-1:0] stat_slot,
  output logic [31:0]   stat_word,
  output logic [IW-1:0] cons_idx,
  output logic          irq,
  input  logic          irq_clr
);
  logic          busy, cur_irq;
  logic [IW-1:0] nxt_idx;
  logic [3:0]    coll_sat;
  logic [7:0]    coll_fields;
  logic          done, no_desc, err;
  logic [31:0]   word;

  assign nxt_idx  = (cons_idx == IW'(RING - 1)) ? '0 : cons_idx + 1'b1;
  assign done     = busy & mac_done;
  assign no_desc  = ~frag_last & (nxt_idx == prod_idx);
  assign coll_sat = (mac_coll_cnt > 4'(MAX_RETX)) ? 4'(MAX_RETX) : mac_coll_cnt;
  assign coll_fields = frag_last ?
    {mac_late_coll, mac_exc_coll, mac_exc_defer, mac_defer, coll_sat} : 8'd0;
  assign err  = mac_underrun | no_desc | coll_fields[7] | coll_fields[6] | coll_fields[5];
  assign word = {err, no_desc, mac_underrun, coll_fields, 21'd0};

  assign frag_valid = busy;
  assign frag_slot  = cons_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_irq   <= 1'b0;
      frag_last <= 1'b0;
      cons_idx  <= '0;
      stat_we   <= 1'b0;
      stat_slot <= '0;
      stat_word <= '0;
      irq       <= 1'b0;
    end else begin
      stat_we <= done;
      if (done) begin
        stat_word <= word;
        stat_slot <= cons_idx;
        cons_idx  <= nxt_idx;
        busy      <= 1'b0;
      end else if (!busy && cons_idx != prod_idx) begin
        busy      <= 1'b1;
        frag_last <= desc_last;
        cur_irq   <= desc_irq;
      end
      if (done && cur_irq) irq <= 1'b1;
      else if (irq_clr)    irq <= 1'b0;
    end
  end
endmodule

module tx_status_engine_chk #(
  parameter int RING = 6,
  parameter int MAX_RETX = 10,
  localparam int IW = (RING > 1) ? $clog2(RING) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frag_valid,
  input logic          frag_last,
  input logic          stat_we,
  input logic [IW-1:0] stat_slot,
  input logic [31:0]   stat_word,
  input logic [IW-1:0] cons_idx,
  input logic          irq,
  input logic          irq_clr
);
  a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> stat_word[20:0] == 21'd0);
  a_r7_error_sum: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> stat_word[31] == (|stat_word[30:26]));
  a_r6_open_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> ($past(frag_last) || stat_word[28:21] == 8'd0));
  a_r5_count_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> stat_word[24:21] <= 4'(MAX_RETX));
  a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> (stat_slot == $past(cons_idx)) &&
      (cons_idx == (($past(cons_idx) == IW'(RING - 1)) ? '0 : $past(cons_idx) + 1'b1)));
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> !stat_we);
  a_r3_strobe_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |-> $past(frag_valid));
  a_r9_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);
endmodule

bind tx_status_engine tx_status_engine_chk #(.RING(RING), .MAX_RETX(MAX_RETX)) u_chk (
  .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_last(frag_last),
  .stat_we(stat_we), .stat_slot(stat_slot), .stat_word(stat_word),
  .cons_idx(cons_idx), .irq(irq), .irq_clr(irq_clr));

// File: tb/tb_tx_status_engine.sv
module tb_tx_status_engine;
  localparam int RING = 6;
  localparam int MAX_RETX = 10;
  localparam int IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [IW-1:0] prod_idx = '0;
  logic desc_last = 1'b0, desc_irq = 1'b0, mac_done = 1'b0, irq_clr = 1'b0;
  logic [3:0] mac_coll_cnt = '0;
  logic mac_defer = 0, mac_exc_defer = 0, mac_exc_coll = 0, mac_late_coll = 0, mac_underrun = 0;
  logic frag_valid, frag_last, stat_we, irq;
  logic [IW-1:0] frag_slot, stat_slot, cons_idx;
  logic [31:0] stat_word;

  always #2.5 clk = ~clk;

  tx_status_engine #(.RING(RING), .MAX_RETX(MAX_RETX)) dut (
    .clk(clk), .rst_n(rst_n), .prod_idx(prod_idx), .desc_last(desc_last), .desc_irq(desc_irq),
    .frag_valid(frag_valid), .frag_slot(frag_slot), .frag_last(frag_last),
    .mac_done(mac_done), .mac_coll_cnt(mac_coll_cnt), .mac_defer(mac_defer),
    .mac_exc_defer(mac_exc_defer), .mac_exc_coll(mac_exc_coll), .mac_late_coll(mac_late_coll),
    .mac_underrun(mac_underrun), .stat_we(stat_we), .stat_slot(stat_slot), .stat_word(stat_word),
    .cons_idx(cons_idx), .irq(irq), .irq_clr(irq_clr));

  // {last, irq, more, coll[3:0], defer, exc_defer, exc_coll, late, underrun}
  localparam logic [11:0] VEC [10] = '{
    12'b1_0_0_0011_1_0_0_0_0,
    12'b0_0_1_0010_1_0_0_1_1,
    12'b1_1_0_1101_0_0_1_0_0,
    12'b0_0_0_0101_1_0_0_0_0,
    12'b1_0_0_0000_1_1_0_0_0,
    12'b0_0_1_0111_0_0_0_1_0,
    12'b0_0_1_0000_0_0_0_0_1,
    12'b1_0_0_1111_0_0_0_1_0,
    12'b1_0_1_1010_0_0_0_0_0,
    12'b1_1_0_0001_1_0_0_0_1
  };

  int n_chk = 0, n_bad = 0;
  logic [IW-1:0] ec = '0;
  logic eirq = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  function automatic logic [IW-1:0] wrap(input int v);
    return IW'(v % RING);
  endfunction

  function automatic logic [31:0] expw(input logic last, input logic nod, input logic [3:0] coll,
      input logic def, input logic exd, input logic exc, input logic late, input logic und);
    logic [3:0] c;
    c = (coll > 4'(MAX_RETX)) ? 4'(MAX_RETX) : coll;
    if (!last) begin c = 0; def = 0; exd = 0; exc = 0; late = 0; end
    return {und | nod | exd | exc | late, nod, und, late, exc, exd, def, c, 21'd0};
  endfunction

  task automatic run_frag(input logic [11:0] v, input logic clr_at_done);
    logic last, more;
    last = v[11]; more = v[9];
    desc_last = last; desc_irq = v[10];
    prod_idx = wrap(int'(ec) + (more ? 2 : 1));
    for (int i = 0; i < 10 && !frag_valid; i++) tick();
    chk("R2 frag_valid", 32'(frag_valid), 32'd1);
    chk("R2 frag_slot", 32'(frag_slot), 32'(ec));
    chk("R2 frag_last", 32'(frag_last), 32'(last));
    mac_coll_cnt = v[8:5]; mac_defer = v[4]; mac_exc_defer = v[3];
    mac_exc_coll = v[2]; mac_late_coll = v[1]; mac_underrun = v[0];
    mac_done = 1'b1; irq_clr = clr_at_done;
    tick();
    mac_done = 1'b0; irq_clr = 1'b0;
    chk("R3 stat_we", 32'(stat_we), 32'd1);
    chk("R3 stat_slot", 32'(stat_slot), 32'(ec));
    chk("R5/R6/R7/R8/R4 stat_word", stat_word,
        expw(last, !last && !more, v[8:5], v[4], v[3], v[2], v[1], v[0]));
    ec = wrap(int'(ec) + 1);
    chk("R3 cons_idx", 32'(cons_idx), 32'(ec));
    eirq = eirq | v[10];
    chk("R9 irq", 32'(irq), 32'(eirq));
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    chk("R1 cons_idx", 32'(cons_idx), 32'd0);
    chk("R1 frag_valid", 32'(frag_valid), 32'd0);
    chk("R1 stat_we", 32'(stat_we), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);

    tick(); tick();
    chk("R2 idle no fragment", 32'(frag_valid), 32'd0);

    mac_done = 1'b1;
    tick(); tick();
    mac_done = 1'b0;
    chk("R10 no strobe", 32'(stat_we), 32'd0);
    tick();
    chk("R10 no strobe late", 32'(stat_we), 32'd0);
    chk("R10 cons_idx held", 32'(cons_idx), 32'd0);

    foreach (VEC[k]) run_frag(VEC[k], 1'b0);

    tick();
    chk("R3 single strobe", 32'(stat_we), 32'd0);
    chk("R2 ring drained", 32'(frag_valid), 32'd0);

    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    eirq = 1'b0;
    chk("R9 cleared", 32'(irq), 32'd0);
    run_frag(12'b1_1_0_0000_0_0_0_0_0, 1'b1);
    chk("R9 set wins", 32'(irq), 32'd1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    eirq = 1'b0;
    chk("R9 clear after set", 32'(irq), 32'd0);
    run_frag(12'b1_0_0_0000_0_0_0_0_0, 1'b0);
    chk("R9 no request no irq", 32'(irq), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule